// File: doc/BRIEF.md
# Implicit Message Forwarding Decision

This block decides where a message packet goes inside a packet switch that has one port facing the root of the tree and a parameterised number of ports facing the leaves. It reads three things for each header: the index of the port the header arrived on, a flag that marks the packet as a message, and the 3-bit implicit routing code. It does not use an address or a device ID. From these it produces an egress mask with one bit per port and three flags: malformed, consume-here and hand-to-other-path.

The routing code names a well-known destination. The block checks whether the packet is travelling in the direction that code allows, and it copies broadcasts to every leaf-facing port in the same decision. A packet moving the wrong way is flagged as malformed and goes nowhere. A mode input switches the block to leaf-device behaviour, which ignores the arrival port. Headers enter on a valid/ready handshake. Each decision is registered and offered on a second valid/ready handshake one cycle after the header is accepted.

Top module: `msg_route_decide`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: In switch mode (`ep_mode`=0), a message with code 3'b000 (toward root) or 3'b101 (gather toward root) that arrives on a leaf-facing port (index 1..NUM_DN) yields an egress mask of only bit 0. Bit 0 is the root-facing port. All three flags are 0.
- R3: In switch mode, a message with code 3'b011 (broadcast) that arrives on port 0 yields a mask with bits 1..NUM_DN all set and bit 0 clear. All three flags are 0.
- R4: In switch mode, a broadcast (3'b011) that arrives on a leaf-facing port sets `out_malformed` and yields an all-zero mask.
- R5: In switch mode, a 3'b000 or 3'b101 message that arrives on port 0 sets `out_malformed` and yields an all-zero mask.
- R6: A message with code 3'b100 (terminate at receiver) sets `out_consume` and yields an all-zero mask on any port and in either mode.
- R7: Codes 3'b001 and 3'b010 set `out_bypass` with an all-zero mask. Any header with `in_is_msg`=0 also sets `out_bypass`, whatever its code.
- R8: Codes 3'b110 and 3'b111 set `out_malformed` and yield an all-zero mask.
- R9: In endpoint mode (`ep_mode`=1) the arrival port has no effect. Code 3'b011 sets `out_consume`. Codes 3'b000 and 3'b101 are dropped: the mask is zero and all three flags are zero.
- R10: A header accepted on a clock edge shows up on the outputs with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the outputs hold steady.
- R11: At most one of `out_malformed`, `out_consume` and `out_bypass` is set. The mask is zero whenever any of them is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_mode | input | 1 | 1 selects leaf-device behaviour |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_port | input | PORT_W | Arrival port index, 0 is root-facing |
| in_is_msg | input | 1 | Header is a message |
| in_route | input | 3 | Implicit routing code |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision taken downstream |
| out_egress | output | NUM_DN+1 | Egress mask, bit 0 root-facing |
| out_malformed | output | 1 | Packet rejected as malformed |
| out_consume | output | 1 | Packet ends at this receiver |
| out_bypass | output | 1 | Packet goes to the address/ID path |

## Verification
The assertions assume that `in_port` never exceeds NUM_DN while `in_valid` is high. They also assume that `ep_mode` is held steady for as long as a header is waiting to be accepted. The stimulus table uses only port indices 0..4 with NUM_DN=4. The mode changes only between transactions, while `in_valid` is low. The stall test keeps a second header pending against a held decision, so that the hold properties are exercised under back-pressure.

// File: rtl/msg_route_decide.sv
module msg_route_decide #(
  parameter int NUM_DN = 4,
  localparam int MASK_W = NUM_DN + 1,
  localparam int PORT_W = (MASK_W > 2) ? $clog2(MASK_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_is_msg,
  input  logic [2:0]        in_route,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MASK_W-1:0] out_egress,
  output logic              out_malformed,
  output logic              out_consume,
  output logic              out_bypass
);
  localparam logic [2:0] RC_ROOT   = 3'b000;
  localparam logic [2:0] RC_ADDR   = 3'b001;
  localparam logic [2:0] RC_ID     = 3'b010;
  localparam logic [2:0] RC_BCAST  = 3'b011;
  localparam logic [2:0] RC_LOCAL  = 3'b100;
  localparam logic [2:0] RC_GATHER = 3'b101;

  localparam logic [MASK_W-1:0] UP_MASK = MASK_W'(1);
  localparam logic [MASK_W-1:0] DN_MASK = {{NUM_DN{1'b1}}, 1'b0};

  logic              from_up;
  logic              accept;
  logic [MASK_W-1:0] d_mask;
  logic              d_mal, d_con, d_byp;

  assign from_up  = (in_port == '0);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    d_mask = '0;
    d_mal  = 1'b0;
    d_con  = 1'b0;
    d_byp  = 1'b0;
    if (!in_is_msg) begin
      d_byp = 1'b1;
    end else begin
      case (in_route)
        RC_ROOT, RC_GATHER: begin
          if (!ep_mode) begin
            if (from_up) d_mal = 1'b1;
            else         d_mask = UP_MASK;
          end
        end
        RC_BCAST: begin
          if (ep_mode)      d_con = 1'b1;
          else if (from_up) d_mask = DN_MASK;
          else              d_mal = 1'b1;
        end
        RC_LOCAL:      d_con = 1'b1;
        RC_ADDR, RC_ID: d_byp = 1'b1;
        default:       d_mal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_egress    <= '0;
      out_malformed <= 1'b0;
      out_consume   <= 1'b0;
      out_bypass    <= 1'b0;
    end else begin
      if (accept) begin
        out_valid     <= 1'b1;
        out_egress    <= d_mask;
        out_malformed <= d_mal;
        out_consume   <= d_con;
        out_bypass    <= d_byp;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module msg_route_chk #(
  parameter int NUM_DN = 4,
  localparam int MASK_W = NUM_DN + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [MASK_W-1:0] out_egress,
  input logic              out_malformed,
  input logic              out_consume,
  input logic              out_bypass
);
  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_egress)
      && $stable(out_malformed) && $stable(out_consume) && $stable(out_bypass));

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_malformed, out_consume, out_bypass}) <= 1);

  a_r11_flag_no_egress: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_malformed || out_consume || out_bypass) |-> out_egress == '0);

  a_r3_fanout_whole: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (|out_egress[MASK_W-1:1]) |-> (&out_egress[MASK_W-1:1]) && !out_egress[0]);

  a_r2_up_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_egress[0] |-> out_egress[MASK_W-1:1] == '0);
endmodule

bind msg_route_decide msg_route_chk #(.NUM_DN(NUM_DN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_egress(out_egress),
  .out_malformed(out_malformed), .out_consume(out_consume), .out_bypass(out_bypass)
);

// File: tb/sim_msg_route_decide.sv
`timescale 1ns/1ps
module sim_msg_route_decide;
  localparam int N = 4;
  localparam int PW = 3;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_mode = 1'b0, in_valid = 1'b0, in_is_msg = 1'b0, out_ready = 1'b1;
  logic [PW-1:0] in_port = '0;
  logic [2:0] in_route = '0;
  logic in_ready, out_valid, out_malformed, out_consume, out_bypass;
  logic [N:0] out_egress;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  msg_route_decide #(.NUM_DN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ep_mode(ep_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_port(in_port), .in_is_msg(in_is_msg),
    .in_route(in_route), .out_valid(out_valid), .out_ready(out_ready),
    .out_egress(out_egress), .out_malformed(out_malformed),
    .out_consume(out_consume), .out_bypass(out_bypass)
  );

  // {req[3:0], ep, port[2:0], msg, route[2:0], mask[4:0], mal, con, byp}
  localparam logic [19:0] VEC [NV] = '{
    20'b0010_0_001_1_000_00001_000, // R2
    20'b0010_0_100_1_101_00001_000, // R2 gather
    20'b0011_0_000_1_011_11110_000, // R3
    20'b0100_0_010_1_011_00000_100, // R4
    20'b0101_0_000_1_000_00000_100, // R5
    20'b0101_0_000_1_101_00000_100, // R5
    20'b0110_0_011_1_100_00000_010, // R6
    20'b0110_0_000_1_100_00000_010, // R6
    20'b0111_0_001_1_001_00000_001, // R7
    20'b0111_0_000_1_010_00000_001, // R7
    20'b0111_0_010_0_000_00000_001, // R7 non-message
    20'b1000_0_001_1_110_00000_100, // R8
    20'b1000_0_000_1_111_00000_100, // R8
    20'b1001_1_000_1_011_00000_010, // R9
    20'b1001_1_011_1_100_00000_010, // R9
    20'b1001_1_000_1_000_00000_000, // R9 dropped
    20'b1001_1_010_1_101_00000_000, // R9 dropped
    20'b1001_1_001_1_001_00000_001  // R9
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ep, input logic [PW-1:0] p, input logic m, input logic [2:0] r);
    @(negedge clk);
    ep_mode = ep; in_port = p; in_is_msg = m; in_route = r; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "valid,ready",
          {6'b0, out_valid, in_ready}, 8'b01);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      logic [7:0] exp_o, act_o;
      v = VEC[i];
      drive(v[15], v[14:12], v[11], v[10:8]);
      exp_o = {v[7:0]};
      act_o = {out_egress, out_malformed, out_consume, out_bypass};
      check(out_valid && act_o == exp_o, $sformatf("R%0d", v[19:16]),
            $sformatf("vector %0d mask+flags", i), act_o, exp_o);
      check($countones({out_malformed, out_consume, out_bypass}) <= 1, "R11",
            "flag count", {5'b0, out_malformed, out_consume, out_bypass}, 8'b0);
    end

    // R10: stall holds the decision and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 3'd0, 1'b1, 3'b011);
    check(out_valid && out_egress == 5'b11110, "R10", "first decision",
          {3'b0, out_egress}, 8'b00011110);
    ep_mode = 1'b0; in_port = 3'd3; in_is_msg = 1'b1; in_route = 3'b000; in_valid = 1'b1;
    check(in_ready == 1'b0, "R10", "ready while stalled", {7'b0, in_ready}, 8'b0);
    repeat (3) @(negedge clk);
    check(out_valid && out_egress == 5'b11110 && in_ready == 1'b0, "R10",
          "held after stall", {2'b0, out_valid, out_egress}, 8'b00111110);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_egress == 5'b00001, "R10", "pending header taken",
          {2'b0, out_valid, out_egress}, 8'b00100001);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid drops when drained", {7'b0, out_valid}, 8'b0);

    // R9: port ignored in endpoint mode, including leaf-facing ports
    drive(1'b1, 3'd4, 1'b1, 3'b011);
    check(out_consume && !out_malformed && out_egress == '0, "R9", "ep bcast port4",
          {3'b0, out_egress}, 8'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule